// File: doc/BRIEF.md
# Temperature Alarm Register Bank

This block is the digital core of a memory-module thermal sensor. A register file of 16-bit words sits behind an 8-bit pointer. It stores a configuration word and three temperature limits: upper, lower and critical. It also exposes a capability word and two fixed identity words. An external converter supplies 13-bit two's-complement samples at 0.0625 °C per LSB. Each accepted sample is compared against the limits, and the three alarm flags it produces are packed above the temperature field of the readback word.

The alarms use hysteresis. A flag sets as soon as its threshold is crossed. It clears only after the temperature has moved back past the threshold by one of four coded amounts. A registered, active-low event pin reports the alarms, either all three or the critical alarm alone. Two sticky lock bits protect the limits: one for the critical limit and one for the upper and lower limits. A shutdown bit freezes the temperature and the flags. Software reaches the bank through a plain parallel port with a combinational read and a single-cycle write.

Top module: `tsense_regbank`

## Requirements
- R1: After reset, every writable register, the temperature field and all alarm flags read zero, and `event_n` is high.
- R2: Read map: pointer 0x00 reads the capability word, 0x06 the manufacturer code and 0x07 the device code. In the capability word, bit 2 equals the extended-range parameter and all other bits are zero. Configuration bits 15:11 read zero, limit words read zero in bits 15:13, and any unmapped pointer reads zero.
- R3: Only pointers 0x01 to 0x04 accept writes. A write to any other pointer changes no readable value.
- R4: A limit write takes data bits 12:0 as a signed value and clamps it to at most 2000 (125 °C). The lower bound of the clamp is -640 (-40 °C) when extended range is enabled, and 0 otherwise.
- R5: The temperature word holds the last accepted sample in bits 12:0. Bit 15 is the critical flag, bit 14 the above-upper flag and bit 13 the below-lower flag. Flags update on the same clock edge as the temperature field.
- R6: The above-upper flag sets when temp > upper. It clears when temp <= upper - H. Otherwise it holds.
- R7: The below-lower flag sets when temp < lower. It clears when temp >= lower + H. Otherwise it holds.
- R8: The critical flag sets when temp >= critical. It clears when temp < critical - H. Otherwise it holds.
- R9: H is chosen by configuration bits 10:9. Code 0 gives 0, code 1 gives 24, code 2 gives 48 and code 3 gives 96 LSB.
- R10: While configuration bit 6 is set, writes to the critical limit are ignored.
- R11: While configuration bit 7 is set, writes to the upper and lower limits are ignored.
- R12: Once set, configuration bits 6 and 7 stay set until reset.
- R13: While configuration bit 8 (shutdown) is set, samples are ignored: the temperature field and the flags hold.
- R14: One clock after the flags, `event_n` goes low if any flag is set. When configuration bit 2 is set, only the critical flag drives it. Otherwise `event_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_ptr | input | 8 | Register pointer for read and write |
| acc_wr | input | 1 | Write strobe, one cycle |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Combinational read data at `acc_ptr` |
| smp_valid | input | 1 | Converter sample strobe |
| smp_temp | input | 13 | Converter sample, two's complement |
| event_n | output | 1 | Registered active-low alarm event |

## Verification
The main instance is built with extended range enabled. This makes negative lower limits and below-zero samples reachable, so the lower-alarm hysteresis can be exercised on both sides of zero. A second instance with extended range disabled receives the same stimulus. It is checked only for a zero capability bit and for a negative lower-limit write clamping to zero. Default identity codes are used, and the 2000 ceiling is reached by writing an oversized limit.

// File: rtl/tsense_pkg.sv
`timescale 1ns/1ps
// Package: shared pointer codes, configuration bit positions, alarm
// record and hysteresis decode for the temperature alarm register bank.
package tsense_pkg;
    localparam int WORD_W = 16;
    localparam int PTR_W  = 8;
    localparam int CFG_W  = 11;

    localparam logic [PTR_W-1:0] PTR_CAP   = 8'h00;
    localparam logic [PTR_W-1:0] PTR_CFG   = 8'h01;
    localparam logic [PTR_W-1:0] PTR_UPPER = 8'h02;
    localparam logic [PTR_W-1:0] PTR_LOWER = 8'h03;
    localparam logic [PTR_W-1:0] PTR_CRIT  = 8'h04;
    localparam logic [PTR_W-1:0] PTR_TEMP  = 8'h05;
    localparam logic [PTR_W-1:0] PTR_MFR   = 8'h06;
    localparam logic [PTR_W-1:0] PTR_DEV   = 8'h07;

    localparam int CB_CRIT_ONLY = 2;
    localparam int CB_CRIT_LOCK = 6;
    localparam int CB_EVT_LOCK  = 7;
    localparam int CB_SHDN      = 8;
    localparam int CB_HYST_LO   = 9;

    typedef struct packed {
        logic crit;
        logic above;
        logic below;
    } alarm_t;

    // Hysteresis width in LSB for a two-bit code.
    function automatic logic [6:0] hyst_lsb(input logic [1:0] code);
        case (code)
            2'd1:    return 7'd24;
            2'd2:    return 7'd48;
            2'd3:    return 7'd96;
            default: return 7'd0;
        endcase
    endfunction
endpackage

// File: rtl/tsense_limits.sv
`timescale 1ns/1ps
// tsense_limits: configuration word and the three limit registers.
// Applies sticky lock bits and clamps written limits to the legal range.
// Assumes one write per cycle, decoded from the pointer in the same cycle.
module tsense_limits
    import tsense_pkg::*;
#(
    parameter int TEMP_W        = 13,
    parameter bit EXT_RANGE     = 1'b1,
    parameter int LIMIT_MAX     = 2000,
    parameter int LIMIT_MIN_EXT = -640
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [PTR_W-1:0]         ptr,
    input  logic [CFG_W-1:0]         wr_cfg,
    input  logic [TEMP_W-1:0]        wr_val,
    output logic [CFG_W-1:0]         cfg_q,
    output logic signed [TEMP_W-1:0] upper_q,
    output logic signed [TEMP_W-1:0] lower_q,
    output logic signed [TEMP_W-1:0] crit_q
);
    localparam int CW = TEMP_W + 2;
    localparam int LO_BOUND = EXT_RANGE ? LIMIT_MIN_EXT : 0;
    localparam logic signed [CW-1:0] HI_B = CW'(LIMIT_MAX);
    localparam logic signed [CW-1:0] LO_B = CW'(LO_BOUND);

    logic signed [CW-1:0]     wv;
    logic signed [TEMP_W-1:0] clamped;
    logic [CFG_W-1:0]         cfg_next;
    logic                     evt_locked, crit_locked;

    assign wv          = $signed({{(CW-TEMP_W){wr_val[TEMP_W-1]}}, wr_val});
    assign evt_locked  = cfg_q[CB_EVT_LOCK];
    assign crit_locked = cfg_q[CB_CRIT_LOCK];

    // Clamp the written limit into the legal window.
    always_comb begin
        if (wv > HI_B)      clamped = HI_B[TEMP_W-1:0];
        else if (wv < LO_B) clamped = LO_B[TEMP_W-1:0];
        else                clamped = wv[TEMP_W-1:0];
    end

    // Next configuration: lock bits are sticky once set.
    always_comb begin
        cfg_next = wr_cfg;
        cfg_next[CB_CRIT_LOCK] = wr_cfg[CB_CRIT_LOCK] | crit_locked;
        cfg_next[CB_EVT_LOCK]  = wr_cfg[CB_EVT_LOCK]  | evt_locked;
    end

    // Register writes, gated by the lock bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            upper_q <= '0;
            lower_q <= '0;
            crit_q  <= '0;
        end else if (wr_en) begin
            case (ptr)
                PTR_CFG:   cfg_q <= cfg_next;
                PTR_UPPER: if (!evt_locked)  upper_q <= clamped;
                PTR_LOWER: if (!evt_locked)  lower_q <= clamped;
                PTR_CRIT:  if (!crit_locked) crit_q  <= clamped;
                default: ;
            endcase
        end
    end

    AST_CRIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_locked && wr_en && ptr == PTR_CRIT) |=> $stable(crit_q)); // R10
    AST_EVT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_locked && wr_en && (ptr == PTR_UPPER || ptr == PTR_LOWER))
        |=> ($stable(upper_q) && $stable(lower_q))); // R11
    AST_CRIT_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        crit_locked |=> cfg_q[CB_CRIT_LOCK]); // R12
    AST_EVT_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_locked |=> cfg_q[CB_EVT_LOCK]); // R12
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ptr < PTR_CFG || ptr > PTR_CRIT))
        |=> ($stable(cfg_q) && $stable(upper_q) && $stable(lower_q) && $stable(crit_q))); // R3
    AST_LIMIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(upper_q) <= HI_B && CW'(upper_q) >= LO_B && CW'(crit_q) <= HI_B
         && CW'(crit_q) >= LO_B && CW'(lower_q) <= HI_B && CW'(lower_q) >= LO_B)); // R4
endmodule

// File: rtl/tsense_alarm.sv
`timescale 1ns/1ps
// tsense_alarm: captures converter samples and evaluates the three alarm
// flags with hysteresis. Flags are re-evaluated only when a sample is
// accepted; shutdown blocks acceptance. Limits are used as currently held.
module tsense_alarm
    import tsense_pkg::*;
#(
    parameter int TEMP_W = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [TEMP_W-1:0]        smp_temp,
    input  logic                     shutdown,
    input  logic [1:0]               hyst_code,
    input  logic signed [TEMP_W-1:0] upper,
    input  logic signed [TEMP_W-1:0] lower,
    input  logic signed [TEMP_W-1:0] crit,
    output logic [TEMP_W-1:0]        temp_q,
    output alarm_t                   flags_q
);
    localparam int CW = TEMP_W + 2;

    logic signed [CW-1:0] t, u, l, c, h;
    logic                 take;
    alarm_t               flags_d;

    assign take = smp_valid && !shutdown;
    assign t = $signed({{(CW-TEMP_W){smp_temp[TEMP_W-1]}}, smp_temp});
    assign u = CW'(upper);
    assign l = CW'(lower);
    assign c = CW'(crit);
    assign h = $signed({{(CW-7){1'b0}}, hyst_lsb(hyst_code)});

    // Set-on-cross, clear-after-hysteresis evaluation of each flag.
    always_comb begin
        flags_d.above = (t > u)  || (flags_q.above && !(t <= u - h));
        flags_d.below = (t < l)  || (flags_q.below && !(t >= l + h));
        flags_d.crit  = (t >= c) || (flags_q.crit  && !(t < c - h));
    end

    // Capture the sample and flags together when accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q  <= '0;
            flags_q <= '0;
        end else if (take) begin
            temp_q  <= smp_temp;
            flags_q <= flags_d;
        end
    end

    AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> ($stable(temp_q) && $stable(flags_q))); // R13
    AST_FLAGS_NEED_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(flags_q)); // R5
    AST_ABOVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && t > u) |=> flags_q.above); // R6
    AST_CRIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && t >= c) |=> flags_q.crit); // R8
    AST_BELOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && t < l) |=> flags_q.below); // R7
endmodule

// File: rtl/tsense_event.sv
`timescale 1ns/1ps
// tsense_event: registered active-low event pin built from the alarm
// flags, optionally restricted to the critical flag.
module tsense_event
    import tsense_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  alarm_t flags,
    input  logic   crit_only,
    output logic   event_n
);
    logic fire;

    assign fire = crit_only ? flags.crit : (flags.crit | flags.above | flags.below);

    // Register the inverted event condition.
    always_ff @(posedge clk) begin
        if (!rst_n) event_n <= 1'b1;
        else        event_n <= !fire;
    end

    AST_EVENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |=> event_n); // R14
    AST_CRITONLY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_only && !flags.crit) |=> event_n); // R14
    AST_CRIT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        flags.crit |=> !event_n); // R14
endmodule

// File: rtl/tsense_regbank.sv
`timescale 1ns/1ps
// tsense_regbank: top of the temperature alarm register bank. Holds the
// pointer-addressed register file, routes samples to the alarm logic and
// drives the event pin. Reads are combinational; writes take one cycle.
module tsense_regbank
    import tsense_pkg::*;
#(
    parameter int          TEMP_W        = 13,
    parameter bit          EXT_RANGE     = 1'b1,
    parameter int          LIMIT_MAX     = 2000,
    parameter int          LIMIT_MIN_EXT = -640,
    parameter logic [15:0] MFR_CODE      = 16'h1A2B,
    parameter logic [15:0] DEV_CODE      = 16'h3C01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  acc_ptr,
    input  logic              acc_wr,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic [WORD_W-1:0] acc_rdata,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_temp,
    output logic              event_n
);
    localparam int PAD_T = WORD_W - TEMP_W;
    localparam int PAD_C = WORD_W - CFG_W;

    logic [CFG_W-1:0]         cfg_q;
    logic signed [TEMP_W-1:0] upper_q, lower_q, crit_q;
    logic [TEMP_W-1:0]        temp_q;
    alarm_t                   flags_q;
    logic [WORD_W-1:0]        cap_word;

    assign cap_word = {{(WORD_W-3){1'b0}}, EXT_RANGE, 2'b00};

    tsense_limits #(
        .TEMP_W(TEMP_W), .EXT_RANGE(EXT_RANGE),
        .LIMIT_MAX(LIMIT_MAX), .LIMIT_MIN_EXT(LIMIT_MIN_EXT)
    ) u_limits (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_wr), .ptr(acc_ptr),
        .wr_cfg(acc_wdata[CFG_W-1:0]), .wr_val(acc_wdata[TEMP_W-1:0]),
        .cfg_q(cfg_q), .upper_q(upper_q), .lower_q(lower_q), .crit_q(crit_q)
    );

    tsense_alarm #(.TEMP_W(TEMP_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .shutdown(cfg_q[CB_SHDN]), .hyst_code(cfg_q[CB_HYST_LO+1:CB_HYST_LO]),
        .upper(upper_q), .lower(lower_q), .crit(crit_q),
        .temp_q(temp_q), .flags_q(flags_q)
    );

    tsense_event u_event (
        .clk(clk), .rst_n(rst_n), .flags(flags_q),
        .crit_only(cfg_q[CB_CRIT_ONLY]), .event_n(event_n)
    );

    // Combinational read multiplexer over the pointer map.
    always_comb begin
        case (acc_ptr)
            PTR_CAP:   acc_rdata = cap_word;
            PTR_CFG:   acc_rdata = {{PAD_C{1'b0}}, cfg_q};
            PTR_UPPER: acc_rdata = {{PAD_T{1'b0}}, upper_q};
            PTR_LOWER: acc_rdata = {{PAD_T{1'b0}}, lower_q};
            PTR_CRIT:  acc_rdata = {{PAD_T{1'b0}}, crit_q};
            PTR_TEMP:  acc_rdata = {flags_q.crit, flags_q.above, flags_q.below,
                                    {(PAD_T-3){1'b0}}, temp_q};
            PTR_MFR:   acc_rdata = MFR_CODE;
            PTR_DEV:   acc_rdata = DEV_CODE;
            default:   acc_rdata = '0;
        endcase
    end

    AST_EVENT_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> event_n); // R1
endmodule

// File: tb/sim_tsense_regbank.sv
`timescale 1ns/100ps
module sim_tsense_regbank;
    localparam int MFR = 16'h1A2B;
    localparam int DEV = 16'h3C01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  acc_ptr = 8'h00;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_wdata = 16'h0;
    logic        smp_valid = 1'b0;
    logic [12:0] smp_temp = 13'h0;
    logic [15:0] rdata0, rdata1;
    logic        ev0, ev1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tsense_regbank #(.EXT_RANGE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_ptr(acc_ptr), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rdata(rdata0), .smp_valid(smp_valid),
        .smp_temp(smp_temp), .event_n(ev0));

    tsense_regbank #(.EXT_RANGE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_ptr(acc_ptr), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rdata(rdata1), .smp_valid(smp_valid),
        .smp_temp(smp_temp), .event_n(ev1));

    // Reference model of u0.
    int m_cfg, m_up, m_lo, m_cr, m_t;
    bit m_ac, m_ah, m_al, m_ev;

    function automatic int sx13(input int v);
        int r = v & 'h1FFF;
        if (r >= 4096) r = r - 8192;
        return r;
    endfunction

    function automatic int clampl(input int v);
        int s = sx13(v);
        if (s > 2000) s = 2000;
        if (s < -640) s = -640;
        return s;
    endfunction

    function automatic int exp_read(input int p);
        case (p)
            0: return 4;
            1: return m_cfg & 'h7FF;
            2: return m_up & 'h1FFF;
            3: return m_lo & 'h1FFF;
            4: return m_cr & 'h1FFF;
            5: return (int'(m_ac) << 15) | (int'(m_ah) << 14) | (int'(m_al) << 13) | (m_t & 'h1FFF);
            6: return MFR;
            7: return DEV;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int p);
        case (p)
            1: return "R12";
            2, 3: return "R11";
            4: return "R10";
            5: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int p, output int v);
        acc_ptr = p[7:0];
        #0.2;
        v = int'(rdata0);
    endtask

    task automatic rd1(input int p, output int v);
        acc_ptr = p[7:0];
        #0.2;
        v = int'(rdata1);
    endtask

    task automatic check_all();
        int v;
        chk("R14", int'(ev0), int'(m_ev));
        for (int p = 0; p < 9; p++) begin
            rd(p, v);
            chk(tag_of(p), v, exp_read(p));
        end
    endtask

    task automatic model_reset();
        m_cfg = 0; m_up = 0; m_lo = 0; m_cr = 0; m_t = 0;
        m_ac = 0; m_ah = 0; m_al = 0; m_ev = 1;
    endtask

    task automatic tick(input bit wr, input int ptr, input int wd, input bit sv, input int st);
        int code, hy, t;
        bit nev;
        @(negedge clk);
        acc_wr = wr; acc_ptr = ptr[7:0]; acc_wdata = wd[15:0];
        smp_valid = sv; smp_temp = st[12:0];
        @(posedge clk);
        code = (m_cfg >> 9) & 3;
        hy = (code == 0) ? 0 : (24 << (code - 1));
        nev = ((m_cfg & 4) != 0) ? !m_ac : !(m_ac | m_ah | m_al);
        if (sv && ((m_cfg & 'h100) == 0)) begin
            t = sx13(st);
            m_ah = (t > m_up) || (m_ah && !(t <= m_up - hy));
            m_al = (t < m_lo) || (m_al && !(t >= m_lo + hy));
            m_ac = (t >= m_cr) || (m_ac && !(t < m_cr - hy));
            m_t = t;
        end
        if (wr) begin
            case (ptr & 'hFF)
                1: m_cfg = (wd & 'h7FF) | (m_cfg & 'hC0);
                2: if ((m_cfg & 'h80) == 0) m_up = clampl(wd);
                3: if ((m_cfg & 'h80) == 0) m_lo = clampl(wd);
                4: if ((m_cfg & 'h40) == 0) m_cr = clampl(wd);
                default: ;
            endcase
        end
        m_ev = nev;
        #0.5;
        acc_wr = 1'b0; smp_valid = 1'b0;
        check_all();
    endtask

    task automatic wr(input int p, input int d);  tick(1, p, d, 0, 0); endtask
    task automatic smp(input int t);              tick(0, 0, 0, 1, t); endtask
    task automatic idle();                        tick(0, 0, 0, 0, 0); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #0.5;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();
        @(posedge clk); #0.5;
        // R1 reset state
        rd(5, v); chk("R1", v, 0);
        rd(1, v); chk("R1", v, 0);
        rd(2, v); chk("R1", v, 0);
        chk("R1", int'(ev0), 1);
        // R2 read map
        rd(0, v);  chk("R2", v, 4);
        rd1(0, v); chk("R2", v, 0);
        rd(6, v);  chk("R2", v, MFR);
        rd(7, v);  chk("R2", v, DEV);
        rd('h10, v); chk("R2", v, 0);
        // R3 writes outside 0x01..0x04 ignored
        wr(5, 'h0123); wr(0, 'hFFFF); wr(6, 'hFFFF); wr('h22, 'hFFFF);
        rd(5, v); chk("R3", v, 0);
        rd(0, v); chk("R3", v, 4);
        rd(6, v); chk("R3", v, MFR);
        // R4 clamping
        wr(2, 'h0FFF); rd(2, v); chk("R4", v, 'h07D0);
        wr(3, 'h1C18); rd(3, v); chk("R4", v, 'h1D80);
        rd1(3, v); chk("R4", v, 0);
        wr(2, 'hE320); rd(2, v); chk("R4", v, 'h0320);
        wr(4, 'h07D0);
        // R6 / R9 upper alarm, code 1
        wr(1, 'h0200);
        smp(801); rd(5, v); chk("R6", v, 'h4321);
        smp(790); rd(5, v); chk("R6", v, 'h4316);
        smp(776); rd(5, v); chk("R9", v, 'h0308);
        wr(1, 'h0600);
        smp(900); rd(5, v); chk("R9", v, 'h4384);
        smp(705); rd(5, v); chk("R9", v, 'h42C1);
        smp(704); rd(5, v); chk("R9", v, 'h02C0);
        // R7 lower alarm, code 2
        wr(3, 'h1FD8); wr(1, 'h0400);
        smp(-50); rd(5, v); chk("R7", v, 'h3FCE);
        smp(7);   rd(5, v); chk("R7", v, 'h2007);
        smp(8);   rd(5, v); chk("R7", v, 'h0008);
        // R8 critical and R14 event timing
        wr(4, 'h03E8); wr(1, 0);
        smp(1000); rd(5, v); chk("R8", v, 'hC3E8);
        chk("R14", int'(ev0), 1);
        idle(); chk("R14", int'(ev0), 0);
        smp(999); rd(5, v); chk("R8", v, 'h43E7);
        wr(1, 'h0004); chk("R14", int'(ev0), 0);
        idle(); chk("R14", int'(ev0), 1);
        // R13 shutdown
        wr(1, 'h0100);
        smp(1500); rd(5, v); chk("R13", v, 'h43E7);
        wr(1, 0);
        smp(1500); rd(5, v); chk("R13", v, 'hC5DC);
        // R10 R11 R12 locks
        wr(1, 'h00C0);
        wr(4, 'h0100); rd(4, v); chk("R10", v, 'h03E8);
        wr(2, 'h0100); rd(2, v); chk("R11", v, 'h0320);
        wr(1, 0);      rd(1, v); chk("R12", v, 'h00C0);

        // Constrained random segments
        for (int seg = 0; seg < 4; seg++) begin
            do_reset();
            for (int k = 0; k < 600; k++) begin
                int op = $urandom_range(0, 9);
                int base, d;
                case (op)
                    0, 1, 2: begin
                        case ($urandom_range(0, 2))
                            0: base = m_up;
                            1: base = m_lo;
                            default: base = m_cr;
                        endcase
                        smp(base + $urandom_range(0, 240) - 120);
                    end
                    3: smp($urandom_range(0, 2900) - 800);
                    4, 5: begin
                        d = ($urandom_range(0, 2900) - 800) & 'h1FFF;
                        d = d | ($urandom_range(0, 7) << 13);
                        wr($urandom_range(2, 4), d);
                    end
                    6: begin
                        d = $urandom & 'hFE3F;
                        if ($urandom_range(0, 7) == 0) d = d | 'h100;
                        if ($urandom_range(0, 39) == 0) d = d | 'h40;
                        if ($urandom_range(0, 39) == 0) d = d | 'h80;
                        wr(1, d);
                    end
                    7: wr($urandom_range(0, 9), $urandom & 'hFFFF);
                    default: idle();
                endcase
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule